// File: doc/BRIEF.md
# Auto-Reloading Decrementer

This block is a down-counter that software can load and that counts one step on every cycle where a time-base tick enable is high. When the count steps from one to zero, the block records a sticky expiry flag. If automatic reloading is switched on and the reload register holds a nonzero value, the counter restarts from that value instead of stopping at zero.

The flag is cleared by a write-one-to-clear status write. Combined with an interrupt enable, it drives a level interrupt request that stays high until software clears the flag or drops the enable. A processor uses the block for periodic ticks, with reload enabled, or for one-shot delays, with reload disabled.

The counter width is a parameter. A second parameter selects whether the interrupt output comes straight from logic or from a register. Both variants show the same cycle timing at the port.

Top module: `dec_reload_timer`

## Requirements
- R1: The count decreases by exactly one at each clock edge where `tick_en_i` is high, no counter write is present and the count is nonzero. Without a tick the count holds.
- R2: An expiry event is a tick with the count at 1 and no counter write in that cycle. `status_o` is 1 after the same edge.
- R3: `irq_o` is high exactly while `status_o` is 1 and control bit 0 (interrupt enable) is 1. A change to either is visible after the edge that updates it.
- R4: When control bit 1 (reload enable) is 1 and the reload register is nonzero, an expiry event loads the count with the reload register value instead of zero.
- R5: When the reload register holds zero, an expiry event leaves the count at zero even with reload enabled.
- R6: A status write with `sts_wdata_i` = 1 clears `status_o`. A status write with `sts_wdata_i` = 0 leaves it unchanged.
- R7: Reset sets the count, the reload register, both control bits, the status flag and `irq_o` to zero.
- R8: A count of zero stays zero under ticks and produces no further expiry event until software writes a new value.
- R9: A counter write takes priority over a tick in the same cycle. The written value appears after the edge, and the write itself never causes an expiry event, even when the value is 0.
- R10: If a status clear and an expiry event fall in the same cycle, `status_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tick_en_i | input | 1 | Time-base tick enable; one count step per high cycle |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write value |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | CNT_W | Reload register write value |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 2 | Control value: bit 0 interrupt enable, bit 1 reload enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data; 1 clears the flag |
| count_o | output | CNT_W | Current count |
| reload_o | output | CNT_W | Reload register contents |
| ctl_o | output | 2 | Control register contents |
| status_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
A table of vectors loads start counts, reload values and control settings, then applies a given number of ticks. The cases are short one-shot runs that end before zero, runs that end on zero and runs that overshoot it, reloads that wrap once and several times, and a reload value of zero. Together they separate plain decrementing, stopping at zero, reloading and reload suppression, and show whether the interrupt follows its enable. Directed cases then collide a counter write with a tick, and a status clear with an expiry event. They also toggle the enable while the flag is set and reset the block from a loaded state.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;
   localparam int unsigned CTL_W       = 2;
   localparam int unsigned CTL_IEN_BIT = 0;
   localparam int unsigned CTL_ARE_BIT = 1;

   // bit 1: reload enable, bit 0: interrupt enable
   typedef struct packed {
      logic reload_en;
      logic irq_en;
   } ctl_t;
endpackage

// File: rtl/dectmr_ctrl.sv
module dectmr_ctrl
   import dectmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             rld_wr_i,
   input  logic [CNT_W-1:0] rld_wdata_i,
   output ctl_t             ctl_q_o,
   output ctl_t             ctl_d_o,
   output logic [CNT_W-1:0] rld_q_o
);
   ctl_t             ctl_q;
   ctl_t             ctl_d;
   logic [CNT_W-1:0] rld_q;

   always_comb begin
      ctl_d = ctl_q;
      if (ctl_wr_i) begin
         ctl_d.irq_en    = ctl_wdata_i[CTL_IEN_BIT];
         ctl_d.reload_en = ctl_wdata_i[CTL_ARE_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
         rld_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (rld_wr_i) rld_q <= rld_wdata_i;
      end
   end

   assign ctl_q_o = ctl_q;
   assign ctl_d_o = ctl_d;
   assign rld_q_o = rld_q;

   // R7 / control write takes effect at next edge
   p_ctl_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_wr_i |=> (ctl_q.irq_en == $past(ctl_wdata_i[CTL_IEN_BIT])));
endmodule

// File: rtl/dectmr_counter.sv
module dectmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_en_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             reload_en_i,
   input  logic [CNT_W-1:0] rld_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_evt_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             at_one;
   logic             live;
   logic             reload_ok;
   logic             evt;

   assign at_one    = (cnt_q == ONE);
   assign live      = (cnt_q != ZERO);
   assign reload_ok = reload_en_i && (rld_i != ZERO);
   assign evt       = tick_en_i && !wr_i && at_one;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_i) begin
         cnt_d = wdata_i;
      end else if (tick_en_i && live) begin
         if (at_one && reload_ok) cnt_d = rld_i;
         else                     cnt_d = cnt_q - ONE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o      = cnt_q;
   assign zero_evt_o = evt;

   p_decrement_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_en_i && !wr_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
   p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_en_i && !wr_i) |=> $stable(cnt_q));
   p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_evt_o && reload_en_i && rld_i != ZERO) |=> (cnt_q == $past(rld_i)));
   p_no_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_evt_o && (!reload_en_i || rld_i == ZERO)) |=> (cnt_q == ZERO));
   p_stay_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == ZERO && !wr_i) |=> (cnt_q == ZERO));
   p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/dectmr_status.sv
module dectmr_status (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic sts_q_o,
   output logic sts_d_o
);
   logic sts_q;
   logic sts_d;

   always_comb begin
      sts_d = sts_q;
      if (wr_i && wdata_i) sts_d = 1'b0;
      if (evt_i)           sts_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q <= 1'b0;
      else         sts_q <= sts_d;
   end

   assign sts_q_o = sts_q;
   assign sts_d_o = sts_d;

   p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i |=> sts_q);
   p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i && !evt_i) |=> !sts_q);
   p_w0_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i && !evt_i) |=> $stable(sts_q));
   p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i && wr_i && wdata_i) |=> sts_q);
endmodule

// File: rtl/dec_reload_timer.sv
module dec_reload_timer
   import dectmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_en_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             rld_wr_i,
   input  logic [CNT_W-1:0] rld_wdata_i,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             sts_wr_i,
   input  logic             sts_wdata_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic [CTL_W-1:0] ctl_o,
   output logic             status_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("dec_reload_timer: CNT_W must lie in 2..64");
      end
   endgenerate

   ctl_t             ctl_q;
   ctl_t             ctl_d;
   logic [CNT_W-1:0] rld_q;
   logic [CNT_W-1:0] cnt_q;
   logic             zero_evt;
   logic             sts_q;
   logic             sts_d;

   dectmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctl_wr_i    (ctl_wr_i),
      .ctl_wdata_i (ctl_wdata_i),
      .rld_wr_i    (rld_wr_i),
      .rld_wdata_i (rld_wdata_i),
      .ctl_q_o     (ctl_q),
      .ctl_d_o     (ctl_d),
      .rld_q_o     (rld_q)
   );

   dectmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_en_i   (tick_en_i),
      .wr_i        (cnt_wr_i),
      .wdata_i     (cnt_wdata_i),
      .reload_en_i (ctl_q.reload_en),
      .rld_i       (rld_q),
      .cnt_o       (cnt_q),
      .zero_evt_o  (zero_evt)
   );

   dectmr_status u_status (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (zero_evt),
      .wr_i    (sts_wr_i),
      .wdata_i (sts_wdata_i),
      .sts_q_o (sts_q),
      .sts_d_o (sts_d)
   );

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= sts_d && ctl_d.irq_en;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = sts_q && ctl_q.irq_en;
      end
   endgenerate

   assign count_o  = cnt_q;
   assign reload_o = rld_q;
   assign ctl_o    = ctl_q;
   assign status_o = sts_q;

   p_irq_needs_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> status_o);
   p_irq_follows_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o && ctl_o[CTL_IEN_BIT]) |-> irq_o);
   p_evt_raises_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_evt && ctl_d.irq_en) |=> irq_o);
endmodule

// File: tb/dec_reload_timer_tb_top.sv
module dec_reload_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   typedef struct packed {
      logic [W-1:0] start;
      logic [W-1:0] rld;
      logic [1:0]   ctl;
      logic [7:0]   ticks;
      logic [W-1:0] exp_cnt;
      logic         exp_sts;
      logic         exp_irq;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{32'd10, 32'd0, 2'b00, 8'd3, 32'd7, 1'b0, 1'b0},
      '{32'd5,  32'd0, 2'b01, 8'd5, 32'd0, 1'b1, 1'b1},
      '{32'd5,  32'd0, 2'b01, 8'd8, 32'd0, 1'b1, 1'b1},
      '{32'd3,  32'd8, 2'b11, 8'd5, 32'd6, 1'b1, 1'b1},
      '{32'd3,  32'd0, 2'b11, 8'd4, 32'd0, 1'b1, 1'b1},
      '{32'd2,  32'd4, 2'b10, 8'd2, 32'd4, 1'b1, 1'b0},
      '{32'd1,  32'd2, 2'b11, 8'd7, 32'd2, 1'b1, 1'b1},
      '{32'd0,  32'd5, 2'b11, 8'd4, 32'd0, 1'b0, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         cnt_wr = 1'b0;
   logic [W-1:0] cnt_wdata = '0;
   logic         rld_wr = 1'b0;
   logic [W-1:0] rld_wdata = '0;
   logic         ctl_wr = 1'b0;
   logic [1:0]   ctl_wdata = '0;
   logic         sts_wr = 1'b0;
   logic         sts_wdata = 1'b0;
   logic [W-1:0] count;
   logic [W-1:0] reload;
   logic [1:0]   ctl;
   logic         status;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dec_reload_timer #(.CNT_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick),
      .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
      .rld_wr_i(rld_wr), .rld_wdata_i(rld_wdata),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
      .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata),
      .count_o(count), .reload_o(reload), .ctl_o(ctl),
      .status_o(status), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic idle();
      @(negedge clk);
      tick = 0; cnt_wr = 0; rld_wr = 0; ctl_wr = 0; sts_wr = 0; sts_wdata = 0;
   endtask

   task automatic wr_cnt(input logic [W-1:0] v);
      @(negedge clk); cnt_wr = 1; cnt_wdata = v; idle();
   endtask
   task automatic wr_rld(input logic [W-1:0] v);
      @(negedge clk); rld_wr = 1; rld_wdata = v; idle();
   endtask
   task automatic wr_ctl(input logic [1:0] v);
      @(negedge clk); ctl_wr = 1; ctl_wdata = v; idle();
   endtask
   task automatic wr_sts(input logic v);
      @(negedge clk); sts_wr = 1; sts_wdata = v; idle();
   endtask
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
      end
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 count", count, 0);
      chk("R7 status", {31'd0, status}, 0);
      chk("R7 irq", {31'd0, irq}, 0);
      chk("R7 ctl", {30'd0, ctl}, 0);
      rst_n = 1;
      @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R8
      for (int v = 0; v < NVEC; v++) begin
         wr_ctl(2'b00);
         wr_sts(1'b1);
         wr_rld(VECS[v].rld);
         wr_cnt(VECS[v].start);
         wr_ctl(VECS[v].ctl);
         ticks(int'(VECS[v].ticks));
         chk($sformatf("R1/R4/R5/R8 vec%0d count", v), count, VECS[v].exp_cnt);
         chk($sformatf("R2/R8 vec%0d status", v), {31'd0, status}, {31'd0, VECS[v].exp_sts});
         chk($sformatf("R3 vec%0d irq", v), {31'd0, irq}, {31'd0, VECS[v].exp_irq});
      end

      // R1: no tick, count holds
      wr_ctl(2'b00); wr_sts(1'b1); wr_cnt(32'd9);
      repeat (4) idle();
      chk("R1 hold without tick", count, 32'd9);

      // R9: write beats tick
      @(negedge clk); tick = 1; cnt_wr = 1; cnt_wdata = 32'd20; idle();
      chk("R9 write priority", count, 32'd20);
      wr_cnt(32'd1);
      @(negedge clk); tick = 1; cnt_wr = 1; cnt_wdata = 32'd0; idle();
      chk("R9 write zero count", count, 32'd0);
      chk("R9 write zero no event", {31'd0, status}, 0);

      // R6 / R10
      wr_cnt(32'd1); ticks(1);
      chk("R2 status set", {31'd0, status}, 1);
      wr_sts(1'b0);
      chk("R6 write zero keeps", {31'd0, status}, 1);
      wr_sts(1'b1);
      chk("R6 clear", {31'd0, status}, 0);
      wr_cnt(32'd1);
      @(negedge clk); tick = 1; sts_wr = 1; sts_wdata = 1; idle();
      chk("R10 set wins", {31'd0, status}, 1);

      // R3: enable gates level interrupt
      chk("R3 irq off while disabled", {31'd0, irq}, 0);
      wr_ctl(2'b01);
      chk("R3 irq on", {31'd0, irq}, 1);
      wr_ctl(2'b00);
      chk("R3 irq drops with enable", {31'd0, irq}, 0);

      // R7: reset from loaded state
      wr_ctl(2'b11); wr_rld(32'd7); wr_cnt(32'd12);
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk("R7 count after reset", count, 0);
      chk("R7 reload after reset", reload, 0);
      chk("R7 ctl after reset", {30'd0, ctl}, 0);
      chk("R7 status after reset", {31'd0, status}, 0);
      rst_n = 1;
      @(negedge clk);

      done = 1;
      summary();
      $finish;
   end
endmodule